// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Sequencer

This block turns single-byte read requests from an internal valid/ready interface into read cycles on an asynchronous external memory. It drives a 24-bit address bus, an active-low chip select and an active-low read strobe, and it samples an 8-bit data bus. Each returned byte comes back on a one-cycle response strobe.

When page mode is switched on, the block remembers which aligned page the open chip-select window points at. The page is 4, 8, 16 or 32 bytes, chosen by a 2-bit size field. A request that arrives exactly at the end of the current access and stays inside that page keeps chip select low. It then uses the short in-page access time. Any other request is a first access and uses the long access time. That covers a request after the bus went idle, a request to another page, and every request while page mode is off. When such a request follows straight on from a running access, chip select first goes high for one cycle.

Top module: `page_read_seq`

## Requirements
- R1: After reset, chip select and read strobe are high (1), the request-ready output is high and the response strobe is low.
- R2: With the page-enable input at 0, every access uses the long access time, and a request taken at the end of a running access is preceded by one cycle with chip select high.
- R3: The page-size field encodes 0 = 4, 1 = 8, 2 = 16 and 3 = 32 bytes. Two addresses lie in the same page when their bits from position 2 + size upward are equal.
- R4: A first access keeps chip select and read strobe low for exactly the long-length count of cycles, and the read strobe is never low while chip select is high.
- R5: With page mode on, a request taken in the last cycle of an access to the same page keeps chip select low and lasts exactly the short-length count of cycles.
- R6: A request taken in the last cycle of an access to a different page gets one cycle with chip select high, then a long access.
- R7: A request accepted while the sequencer is idle always uses the long access time.
- R8: The byte on the data bus is captured at the clock edge that ends each access and is presented with a response strobe that is high for that one following cycle per access.
- R9: A length value of 0 behaves as a length of 1.
- R10: Request-ready is high only when the sequencer is idle or in the final cycle of an access.
- R11: The address bus carries the accepted request address, unchanged, for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 1 | 1 enables page mode |
| cfg_page_sz | input | 2 | Page size code (0..3 = 4..32 bytes) |
| cfg_first_len | input | 6 | Long (first access) length in cycles |
| cfg_next_len | input | 6 | Short (in-page access) length in cycles |
| req_valid | input | 1 | Read request present |
| req_addr | input | 24 | Byte address of the request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | One-cycle strobe for returned data |
| rsp_data | output | 8 | Returned byte |
| mem_addr | output | 24 | External address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data | input | 8 | External data bus |

## Verification
The hardest case to reach is the in-page hit. It needs a new request present in exactly the last cycle of a running access, and any gap of even one cycle turns it into a first access. The driver therefore raises the next request on the same half-cycle in which it records the previous acceptance, so it is already waiting when ready rises. The bench also runs with zero lengths, so that every cycle is a final cycle. Separate idle waits produce the after-idle case, and page-size changes move the page boundary under otherwise equal address pairs.

// File: rtl/prs_pkg.sv
package prs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_ACCESS = 2'd2
    } seq_state_e;
endpackage

// File: rtl/prs_page_match.sv
// Compares two byte addresses above the in-page offset chosen by size code.
module prs_page_match #(
    parameter int ADDR_W     = 24,
    parameter int SZ_W       = 2,
    parameter int BASE_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [SZ_W-1:0]   page_sz,
    output logic              same_page
);
    localparam int SHIFT_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] page_mask;
    logic [SHIFT_W-1:0] low_bits;

    assign diff     = addr_a ^ addr_b;
    assign low_bits = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(page_sz);

    // one mask bit per address bit: set when the bit belongs to the page number
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign page_mask[i] = (SHIFT_W'(i) >= low_bits);
    end

    assign same_page = ((diff & page_mask) == '0);
endmodule

// File: rtl/prs_pulse_len.sv
// Turns programmed lengths into reload values (length - 1), length 0 acting as 1.
module prs_pulse_len #(
    parameter int LEN_W = 6
) (
    input  logic [LEN_W-1:0] long_len,
    input  logic [LEN_W-1:0] short_len,
    output logic [LEN_W-1:0] long_m1,
    output logic [LEN_W-1:0] short_m1
);
    always_comb begin
        long_m1  = (long_len  == '0) ? '0 : long_len  - LEN_W'(1);
        short_m1 = (short_len == '0) ? '0 : short_len - LEN_W'(1);
    end

    always_comb begin
        p_reload_in_range_r9 : assert ((long_m1 <= long_len) && (short_m1 <= short_len))
            else $error("reload value exceeds programmed length");
    end
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq
    import prs_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 6,
    parameter int SZ_W       = 2,
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_page_en,
    input  logic [SZ_W-1:0]   cfg_page_sz,
    input  logic [LEN_W-1:0]  cfg_first_len,
    input  logic [LEN_W-1:0]  cfg_next_len,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_data
);
    typedef struct packed {
        seq_state_e        state;
        logic [LEN_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } regs_t;

    regs_t r_q, r_d;

    logic              last_cyc;
    logic              accept;
    logic              same_page;
    logic              hit;
    logic [LEN_W-1:0]  long_m1;
    logic [LEN_W-1:0]  short_m1;

    prs_page_match #(
        .ADDR_W    (ADDR_W),
        .SZ_W      (SZ_W),
        .BASE_SHIFT(BASE_SHIFT)
    ) u_match (
        .addr_a   (r_q.addr),
        .addr_b   (req_addr),
        .page_sz  (cfg_page_sz),
        .same_page(same_page)
    );

    prs_pulse_len #(
        .LEN_W(LEN_W)
    ) u_len (
        .long_len (cfg_first_len),
        .short_len(cfg_next_len),
        .long_m1  (long_m1),
        .short_m1 (short_m1)
    );

    always_comb begin
        last_cyc  = (r_q.state == ST_ACCESS) && (r_q.cnt == '0);
        req_ready = (r_q.state == ST_IDLE) || last_cyc;
        accept    = req_valid && req_ready;
        hit       = cfg_page_en && last_cyc && same_page;

        r_d       = r_q;
        r_d.rsp_v = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.state = ST_ACCESS;
                    r_d.cnt   = long_m1;
                    r_d.addr  = req_addr;
                end
            end
            ST_GAP: begin
                r_d.state = ST_ACCESS;
                r_d.cnt   = long_m1;
            end
            ST_ACCESS: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - LEN_W'(1);
                end else begin
                    r_d.rsp_v = 1'b1;
                    r_d.rsp_d = mem_data;
                    if (accept) begin
                        r_d.addr = req_addr;
                        if (hit) begin
                            r_d.cnt = short_m1;
                        end else begin
                            r_d.state = ST_GAP;
                        end
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.addr  <= '0;
            r_q.rsp_v <= 1'b0;
            r_q.rsp_d <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = (r_q.state != ST_ACCESS);
    assign mem_rd_n  = (r_q.state != ST_ACCESS);
    assign rsp_valid = r_q.rsp_v;
    assign rsp_data  = r_q.rsp_d;

    // strobe only inside an asserted chip select
    p_strobe_in_cs_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_cs_n);

    // a follow-on request to another page (or with paging off) opens a gap
    p_gap_on_miss_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_cyc && !hit) |=> (mem_cs_n && !req_ready));

    // an in-page follow-on keeps chip select low
    p_hit_keeps_cs_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> !mem_cs_n);

    // only the in-page offset may move on a hit
    p_upper_bits_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (((mem_addr ^ $past(mem_addr)) >> (BASE_SHIFT + int'(cfg_page_sz))) == '0));

    // address held while an access is still counting
    p_addr_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_ACCESS) && (r_q.cnt != '0)) |=> $stable(mem_addr));

    // a response strobe follows only the final cycle of an access
    p_rsp_after_last_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(last_cyc));

    // ready never shown while a gap or a counting access is in progress
    p_ready_window_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && req_ready) |=> ($past(accept) || mem_cs_n));
endmodule

// File: tb/page_read_seq_test.sv
module page_read_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_page_en = 1'b0;
    logic [1:0]  cfg_page_sz = 2'd0;
    logic [5:0]  cfg_first_len = 6'd5;
    logic [5:0]  cfg_next_len = 6'd2;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [23:0] mem_addr;
    logic        mem_cs_n;
    logic        mem_rd_n;
    logic [7:0]  mem_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int prev_end = -100;
    logic [23:0] prev_addr = '0;
    bit done = 0;

    typedef struct {
        logic [7:0] d;
        int         acc;
        int         lat;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model: byte is a fixed function of the address
    assign mem_data = mem_addr[7:0] ^ mem_addr[15:8] ^ mem_addr[23:16] ^ 8'h5A;

    page_read_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .cfg_page_sz(cfg_page_sz),
        .cfg_first_len(cfg_first_len), .cfg_next_len(cfg_next_len),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // issue a request; called at a negedge, returns at the negedge after acceptance
    task automatic issue(input logic [23:0] a, input string tag);
        int acc;
        int lat;
        int len;
        bit b2b;
        bit hit;
        bit same;
        exp_t e;
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        acc  = cyc + 1;
        b2b  = (acc == prev_end);
        same = ((a ^ prev_addr) >> (2 + int'(cfg_page_sz))) == 0;
        hit  = cfg_page_en && b2b && same;
        len  = hit ? int'(cfg_next_len) : int'(cfg_first_len);
        if (len == 0) len = 1;
        lat  = len + ((b2b && !hit) ? 1 : 0);
        e.d = f_mem(a); e.acc = acc; e.lat = lat; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        prev_end  = acc + lat;
        prev_addr = a;
        if (b2b && !hit) begin
            check(mem_cs_n == 1'b1, {tag, " R6 gap cs"}, mem_cs_n, 1);
        end else begin
            check(!mem_cs_n && !mem_rd_n && mem_addr == a, {tag, " R11 R4 addr/strobe"}, mem_addr, a);
        end
        if (lat > 1)
            check(req_ready == 1'b0, {tag, " R10 ready low mid access"}, req_ready, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(0, "R8 unexpected response", rsp_data, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_data == e.d, {e.tag, " R8 data"}, rsp_data, e.d);
                check(cyc - e.acc == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
            end
        end
    end

    task automatic go_idle();
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_rd_n, "R1 strobes idle in reset", {mem_cs_n, mem_rd_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_rd_n && req_ready && !rsp_valid, "R1 reset state",
              {mem_cs_n, mem_rd_n, req_ready, rsp_valid}, 4'b1110);

        // page mode, 8-byte pages
        cfg_page_en = 1; cfg_page_sz = 2'd1; cfg_first_len = 6'd5; cfg_next_len = 6'd2;
        issue(24'h001000, "R7 R4 first from idle");
        issue(24'h001003, "R5 in-page");
        issue(24'h001007, "R5 in-page top byte");
        issue(24'h001008, "R6 R3 next 8B page");
        go_idle();
        issue(24'h001009, "R7 same page after idle");
        go_idle();

        // 32-byte pages: 0x..00 and 0x..1F share a page
        cfg_page_sz = 2'd3;
        issue(24'h002000, "R7 first 32B");
        issue(24'h00201F, "R3 R5 32B hit");
        issue(24'h002020, "R3 R6 32B miss");
        go_idle();

        // 4-byte pages: 0x..00 and 0x..04 differ
        cfg_page_sz = 2'd0;
        issue(24'h003000, "R7 first 4B");
        issue(24'h003004, "R3 R6 4B miss");
        issue(24'h003007, "R3 R5 4B hit");
        go_idle();

        // page mode off: every follow-on request is a first access with a gap
        cfg_page_en = 0; cfg_page_sz = 2'd2;
        issue(24'h004000, "R2 first");
        issue(24'h004001, "R2 same page no paging");
        go_idle();

        // zero lengths act as one cycle
        cfg_page_en = 1; cfg_first_len = 6'd0; cfg_next_len = 6'd0;
        issue(24'h005000, "R9 zero long");
        issue(24'h005001, "R9 R5 zero short");
        issue(24'h005002, "R9 R5 zero short again");
        go_idle();

        check(q.size() == 0, "R8 all responses seen", q.size(), 0);
        check(mem_cs_n && req_ready, "R1 R10 back to idle", {mem_cs_n, req_ready}, 3);
        finish_run();
    end
endmodule